// File: doc/BRIEF.md
# Challenge-Response Windowed Watchdog

This block supervises a processor by demanding a periodic refresh that lands inside a permitted time slot. After every accepted refresh there is a closed interval in which any refresh is treated as a fault, then an open interval in which a refresh must arrive. Once the watchdog is enabled, and again after every reset it raises, a longer first-update interval gives the software time to perform its first refresh. A missed, early or wrong refresh raises the reset output for a programmable hold time.

Two refresh policies exist. In simple mode any write to the key register counts as a refresh. In challenge mode the value written must equal the successor of the current key in an 8-bit linear feedback sequence, and the stored key then moves to that successor. Software reaches the configuration through a small register port. A write takes effect on the clock edge where `wr_en` is high. A read is combinational from `addr`.

Top module: `chresp_wdt`

## Requirements
- R1: After reset `wd_reset` is 0, the registers at addresses 0, 1, 2 and 4 read 0x00, and the key register at address 3 reads 0x5A.
- R2: Address 0 holds the prescaler divider in bits [5:0] and the mode in bit 6 (0 = challenge, 1 = simple). All window timing counts ticks, and a tick occurs every divider+1 clock cycles.
- R3: Address 2 holds the first-update length code in bits [2:0] and the enable in bit 3. One cycle after the enable is set, a first-update window of 64·2^code ticks begins, and `wd_reset` rises if no valid refresh arrives within it.
- R4: An accepted refresh starts a closed window of (c+1)·8 ticks, where c is bits [7:4] of address 1. Any write to address 3 during the closed window raises `wd_reset`.
- R5: An open window of (o+1)·8 ticks follows the closed window, where o is bits [3:0] of address 1. A valid refresh in this window restarts the closed window. If the open window expires with no refresh, `wd_reset` rises.
- R6: In challenge mode a refresh is valid only if the written value equals the next key, which is {key[6:0], key[7]^key[5]^key[4]^key[3]}. The key register then holds that value.
- R7: In challenge mode, a wrong value written during the first-update or open window raises `wd_reset`, and the key is left unchanged.
- R8: In simple mode any value written to address 3 in the first-update or open window is a valid refresh, and the key register keeps its value.
- R9: Bits [1:0] of address 4 select a hold of 0, 8, 16 or 32 ms, where one ms equals HOLD_MS_CYCLES clocks. `wd_reset` stays high for that many cycles, or for a single cycle when the code is 0. The block then re-enters the first-update window.
- R10: While the enable bit is 0, `wd_reset` stays low and writes to address 3 change neither the key nor the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| wd_reset | output | 1 | Watchdog reset output, active high |

## Verification
The refresh path is driven from a vector table. Each row first refreshes inside the first-update window and then writes again after a chosen number of cycles. The rows place the second write on the last closed cycle and on the first and last open cycles, and they also cover a wrong key, a silent open window and a premature write, in both modes. These rows separate an off-by-one in the window boundaries from a key-check fault. Directed tests time the first-update expiry at two divider settings to expose prescaler errors. They measure the reset pulse width at two hold codes, confirm that a refresh right after the pulse is accepted, and show that key writes are ignored while the watchdog is disabled.

// File: rtl/chresp_wdt.sv
module chresp_wdt #(
  parameter int         HOLD_MS_CYCLES = 2,
  parameter logic [7:0] KEY_INIT       = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       wd_reset
);
  localparam int HOLD_MAX = 32 * HOLD_MS_CYCLES;
  localparam int HW = $clog2(HOLD_MAX + 1);
  localparam int CW = 14;

  typedef enum logic [2:0] {S_IDLE, S_FIRST, S_CLOSED, S_OPEN, S_RESET} st_t;

  function automatic logic [7:0] lfsr_step(input logic [7:0] k);
    return {k[6:0], k[7] ^ k[5] ^ k[4] ^ k[3]};
  endfunction

  logic [6:0]    div_q;
  logic [7:0]    win_q;
  logic [3:0]    ctl_q;
  logic [1:0]    hold_q;
  logic [7:0]    key_q;
  st_t           st, nxt;
  logic [5:0]    pre_cnt;
  logic [CW-1:0] win_cnt;
  logic [HW-1:0] hold_cnt;
  logic [CW-1:0] phase_len;
  logic [HW-1:0] hold_len;

  wire       simple    = div_q[6];
  wire       en        = ctl_q[3];
  wire       key_wr    = wr_en && (addr == 3'd3);
  wire [7:0] key_nxt   = lfsr_step(key_q);
  wire       key_ok    = simple || (wdata == key_nxt);
  wire       tick      = (pre_cnt == div_q[5:0]);
  wire       phase_end = tick && (win_cnt == phase_len - 1'b1);
  wire       timing    = (st == S_FIRST) || (st == S_CLOSED) || (st == S_OPEN);
  wire       good_ref  = en && key_wr && key_ok && ((st == S_FIRST) || (st == S_OPEN));

  always_comb begin
    case (st)
      S_FIRST:  phase_len = CW'(64) << ctl_q[2:0];
      S_CLOSED: phase_len = CW'({win_q[7:4], 3'b000}) + CW'(8);
      S_OPEN:   phase_len = CW'({win_q[3:0], 3'b000}) + CW'(8);
      default:  phase_len = '0;
    endcase
  end

  always_comb begin
    case (hold_q)
      2'd0:    hold_len = HW'(1);
      2'd1:    hold_len = HW'(8 * HOLD_MS_CYCLES);
      2'd2:    hold_len = HW'(16 * HOLD_MS_CYCLES);
      default: hold_len = HW'(32 * HOLD_MS_CYCLES);
    endcase
  end

  always_comb begin
    nxt = st;
    if (!en) nxt = S_IDLE;
    else begin
      case (st)
        S_IDLE:   nxt = S_FIRST;
        S_FIRST,
        S_OPEN: begin
          if (key_wr)         nxt = key_ok ? S_CLOSED : S_RESET;
          else if (phase_end) nxt = S_RESET;
        end
        S_CLOSED: begin
          if (key_wr)         nxt = S_RESET;
          else if (phase_end) nxt = S_OPEN;
        end
        S_RESET:  if (hold_cnt == '0) nxt = S_FIRST;
        default:  nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      win_q  <= '0;
      ctl_q  <= '0;
      hold_q <= '0;
    end else if (wr_en) begin
      case (addr)
        3'd0:    div_q  <= wdata[6:0];
        3'd1:    win_q  <= wdata;
        3'd2:    ctl_q  <= wdata[3:0];
        3'd4:    hold_q <= wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pre_cnt  <= '0;
      win_cnt  <= '0;
      hold_cnt <= '0;
      key_q    <= KEY_INIT;
    end else begin
      st <= nxt;
      if (nxt != st || !timing) begin
        pre_cnt <= '0;
        win_cnt <= '0;
      end else if (tick) begin
        pre_cnt <= '0;
        win_cnt <= win_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
      if (nxt == S_RESET && st != S_RESET) hold_cnt <= hold_len - 1'b1;
      else if (st == S_RESET && hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      if (good_ref && !simple) key_q <= key_nxt;
    end
  end

  assign wd_reset = (st == S_RESET);

  always_comb begin
    case (addr)
      3'd0:    rdata = {1'b0, div_q};
      3'd1:    rdata = win_q;
      3'd2:    rdata = {4'b0, ctl_q};
      3'd3:    rdata = key_q;
      3'd4:    rdata = {6'b0, hold_q};
      default: rdata = '0;
    endcase
  end

  a_r4_closed_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLOSED && en && key_wr) |=> wd_reset);

  a_r6_key_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OPEN && en && key_wr && !simple && wdata == key_nxt) |=> (key_q == $past(wdata)));

  a_r7_wrong_key: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OPEN && en && key_wr && !simple && wdata != key_nxt) |=> (wd_reset && $stable(key_q)));

  a_r8_simple_key_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && simple) |=> $stable(key_q));

  a_r9_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wd_reset) && $past(en) && en) |-> (st == S_FIRST));

  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> !wd_reset);

  a_r10_disabled_key: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && key_wr) |=> $stable(key_q));
endmodule

// File: tb/tb_chresp_wdt.sv
module tb_chresp_wdt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       wd_reset;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  chresp_wdt #(.HOLD_MS_CYCLES(2), .KEY_INIT(8'h5A)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wd_reset(wd_reset));

  always #2 clk = ~clk;

  // row: {simple, good_key, expect_reset, timeout, 4'b0, gap[7:0]}
  localparam logic [15:0] ROWS [8] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'd9},
    {1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'd24},
    {1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 8'd8},
    {1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'd12},
    {1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 8'd24},
    {1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'd16},
    {1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 8'd3},
    {1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 8'd24}
  };

  function automatic logic [7:0] nk(input logic [7:0] k);
    return {k[6:0], k[7] ^ k[5] ^ k[4] ^ k[3]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic first_timeout(input logic [5:0] dv, input string req);
    int t;
    bit early;
    do_reset();
    wr(3'd0, {2'b00, dv});
    @(negedge clk);
    wr(3'd2, 8'h08);
    t = 64 * (dv + 1);
    early = 1'b0;
    for (int i = 1; i <= t; i++) begin
      @(negedge clk);
      if (wd_reset) early = 1'b1;
    end
    chk(!early, req, early, 0);
    @(negedge clk);
    chk(wd_reset === 1'b1, req, wd_reset, 1);
  endtask

  task automatic hold_test(input logic [1:0] code, input int exp_len);
    int cnt;
    logic [7:0] k;
    do_reset();
    wr(3'd4, {6'b0, code});
    @(negedge clk);
    wr(3'd2, 8'h08);
    @(negedge clk);
    wr(3'd3, ~nk(8'h5A));
    cnt = 0;
    while (wd_reset && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == exp_len, "R9 hold width", cnt, exp_len);
    wr(3'd3, nk(8'h5A));
    chk(wd_reset === 1'b0, "R9 refresh accepted after hold", wd_reset, 0);
    rd(3'd3, k);
    chk(k == nk(8'h5A), "R9 key after refresh", k, nk(8'h5A));
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] key;
    do_reset();
    // R1 reset state
    chk(wd_reset === 1'b0, "R1 reset output", wd_reset, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      if (a == 3) chk(v == 8'h5A, "R1 key reset", v, 8'h5A);
      else chk(v == 8'h00, "R1 reg reset", v, 0);
    end

    // R4 R5 R6 R7 R8 table
    foreach (ROWS[r]) begin
      logic sm, gk, er, to;
      int gap;
      bit early;
      {sm, gk, er, to} = ROWS[r][15:12];
      gap = int'(ROWS[r][7:0]);
      do_reset();
      wr(3'd0, {1'b0, sm, 6'd0});
      @(negedge clk);
      wr(3'd1, 8'h01);
      @(negedge clk);
      wr(3'd2, 8'h08);
      @(negedge clk);
      key = 8'h5A;
      wr(3'd3, sm ? 8'hC3 : nk(key));
      if (!sm) key = nk(key);
      early = 1'b0;
      for (int i = 1; i < gap; i++) begin
        @(negedge clk);
        if (wd_reset) early = 1'b1;
      end
      chk(!early, "R5 no early reset", early, 0);
      if (to) @(negedge clk);
      else begin
        wr(3'd3, (sm || !gk) ? ~nk(key) : nk(key));
        if (!sm && gk && !er) key = nk(key);
      end
      chk(wd_reset === er, er ? "R4 R5 R7 reset expected" : "R6 R8 refresh accepted", wd_reset, er);
      rd(3'd3, v);
      chk(v == key, sm ? "R8 key kept" : "R6 key value", v, key);
    end

    // R3 first window, R2 divider
    first_timeout(6'd0, "R3 first window");
    first_timeout(6'd3, "R2 divided first window");

    // R9 hold
    hold_test(2'd1, 16);
    hold_test(2'd0, 1);

    // R10 disabled
    do_reset();
    wr(3'd3, 8'h33);
    chk(wd_reset === 1'b0, "R10 disabled no reset", wd_reset, 0);
    rd(3'd3, v);
    chk(v == 8'h5A, "R10 disabled key kept", v, 8'h5A);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule